// File: doc/BRIEF.md
# Flash Write-Cycle Qualifier with Lockout

This block sits between the asynchronous bus pins of a flash device and its command state machine. It decides, one bus cycle at a time, whether a write reaches the command register. The chip-enable, write-enable and output-enable strobes are first brought into the clock domain through two-stage synchronisers. A filter then rejects any level that does not stay put for `MIN_W` clock cycles.

A write counts only while chip-enable and write-enable are both low and output-enable is high. It is committed when chip-enable or write-enable goes back high. The block then emits a one-cycle accept pulse carrying the address and data that were on the bus while both strobes were low.

A digital supply-low input locks out all writing. The same lockout aborts any write that is in flight. When supply-low rises, and at power-up, the block asks the command state machine to return to read mode.

Top module: `flash_wr_qualifier`

## Requirements
- R1: A write is accepted when chip-enable low, write-enable low and output-enable high are held together for at least `MIN_W` clock cycles and then chip-enable or write-enable returns high.
- R2: With only one of chip-enable or write-enable low (the other held high), no accept pulse is produced.
- R3: Output-enable low for `MIN_W` or more cycles during the write window cancels the write. An output-enable dip shorter than `MIN_W` cycles does not cancel it.
- R4: A strobe pulse shorter than `MIN_W` cycles produces no accept pulse.
- R5: `acc_pulse` is high for exactly one clock cycle per accepted write. While it is high, `acc_addr` and `acc_data` hold the values present while both strobes were low.
- R6: While `supply_low` is high, no write is accepted.
- R7: Each rising edge of `supply_low` produces a one-cycle `rd_reset_req` pulse.
- R8: During reset, `rd_reset_req` is high and `acc_pulse` is low. `rd_reset_req` drops within a few cycles after reset is released.
- R9: A write whose strobes are low when `supply_low` rises is aborted and never produces an accept pulse, even after the strobes are released.
- R10: Once `supply_low` falls, a new complete write is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip-enable strobe, active low, asynchronous |
| oe_n | input | 1 | Output-enable strobe, active low, asynchronous |
| we_n | input | 1 | Write-enable strobe, active low, asynchronous |
| supply_low | input | 1 | Digital low-supply indication, active high |
| bus_addr | input | AW | Bus address |
| bus_data | input | DW | Bus data |
| acc_pulse | output | 1 | One-cycle write-accept pulse |
| acc_addr | output | AW | Captured address, valid with acc_pulse |
| acc_data | output | DW | Captured data, valid with acc_pulse |
| rd_reset_req | output | 1 | Request to return the command state to read mode |

## Verification
Strobe patterns are applied with each enable dropped alone and with both dropped. Output-enable is held at each level, and the active window is made one cycle shorter than `MIN_W`, exactly `MIN_W`, and longer. Together these separate the logical inhibit from the width filter. A short output-enable dip inside a long write checks that the filter guards the inhibit path as well. Supply-low is raised before a write and in the middle of one, then dropped again. This separates a plain lockout, an abort of a write in flight, and the return to normal acceptance.

// File: rtl/fwq_pkg.sv
package fwq_pkg;
  typedef enum logic [1:0] {
    QS_IDLE   = 2'd0,
    QS_ACTIVE = 2'd1,
    QS_DRAIN  = 2'd2
  } qstate_e;
endpackage

// File: rtl/fwq_sync.sv
module fwq_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/fwq_width_filter.sv
module fwq_width_filter #(
  parameter int   MIN_W   = 4,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = (MIN_W < 2) ? 1 : $clog2(MIN_W + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_d;
  logic          differ;

  assign differ = (din != dout);

  always_comb begin
    cnt_d = '0;
    out_d = dout;
    if (differ) begin
      if (cnt_q >= CW'(MIN_W - 1)) begin
        out_d = din;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dout  <= RST_VAL;
    end else begin
      cnt_q <= cnt_d;
      dout  <= out_d;
    end
  end
endmodule

// File: rtl/fwq_qualify.sv
module fwq_qualify
  import fwq_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_f,
  input  logic          oe_f,
  input  logic          we_f,
  input  logic          lock,
  input  logic          raw_strobe,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  output logic          acc_pulse,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_data,
  output logic          rd_reset_req,
  output logic          in_write
);
  qstate_e       st_q, st_d;
  logic          pulse_d;
  logic          boot_q, lock_prev_q;
  logic [AW-1:0] hold_addr_q;
  logic [DW-1:0] hold_data_q;
  logic          hold_en;
  logic          win_open, strobe_up;

  assign win_open  = !ce_f && !we_f && oe_f;
  assign strobe_up = ce_f || we_f;
  assign hold_en   = raw_strobe && !lock;
  assign in_write  = (st_q == QS_ACTIVE);

  always_comb begin
    st_d    = st_q;
    pulse_d = 1'b0;
    unique case (st_q)
      QS_IDLE: begin
        if (win_open) st_d = lock ? QS_DRAIN : QS_ACTIVE;
      end
      QS_ACTIVE: begin
        if (lock || !oe_f) begin
          st_d = strobe_up ? QS_IDLE : QS_DRAIN;
        end else if (strobe_up) begin
          st_d    = QS_IDLE;
          pulse_d = 1'b1;
        end
      end
      QS_DRAIN: begin
        if (strobe_up) st_d = QS_IDLE;
      end
      default: st_d = QS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= QS_IDLE;
      acc_pulse    <= 1'b0;
      boot_q       <= 1'b1;
      lock_prev_q  <= 1'b1;
      rd_reset_req <= 1'b1;
    end else begin
      st_q         <= st_d;
      acc_pulse    <= pulse_d;
      boot_q       <= 1'b0;
      lock_prev_q  <= lock;
      rd_reset_req <= boot_q || (lock && !lock_prev_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_addr_q <= '0;
      hold_data_q <= '0;
    end else if (hold_en) begin
      hold_addr_q <= bus_addr;
      hold_data_q <= bus_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_addr <= '0;
      acc_data <= '0;
    end else if (pulse_d) begin
      acc_addr <= hold_addr_q;
      acc_data <= hold_data_q;
    end
  end
endmodule

// File: rtl/flash_wr_qualifier.sv
module flash_wr_qualifier #(
  parameter int AW    = 19,
  parameter int DW    = 8,
  parameter int MIN_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          supply_low,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  output logic          acc_pulse,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_data,
  output logic          rd_reset_req
);
  localparam int NCTL = 3;

  logic [1:0]      rst_pipe_q;
  logic            rst_ni;
  logic [NCTL-1:0] ctl_raw, ctl_s, ctl_f;
  logic            lock_s;
  logic            raw_strobe;
  logic            in_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  assign ctl_raw    = {ce_n, oe_n, we_n};
  assign raw_strobe = !ce_n && !we_n;

  fwq_sync #(.W(NCTL), .RST_VAL({NCTL{1'b1}})) u_ctl_sync (
    .clk(clk), .rst_n(rst_ni), .d(ctl_raw), .q(ctl_s)
  );

  fwq_sync #(.W(1), .RST_VAL(1'b1)) u_lock_sync (
    .clk(clk), .rst_n(rst_ni), .d(supply_low), .q(lock_s)
  );

  for (genvar i = 0; i < NCTL; i++) begin : g_filt
    fwq_width_filter #(.MIN_W(MIN_W), .RST_VAL(1'b1)) u_filt (
      .clk(clk), .rst_n(rst_ni), .din(ctl_s[i]), .dout(ctl_f[i])
    );
  end

  fwq_qualify #(.AW(AW), .DW(DW)) u_qual (
    .clk          (clk),
    .rst_n        (rst_ni),
    .ce_f         (ctl_f[2]),
    .oe_f         (ctl_f[1]),
    .we_f         (ctl_f[0]),
    .lock         (lock_s),
    .raw_strobe   (raw_strobe),
    .bus_addr     (bus_addr),
    .bus_data     (bus_data),
    .acc_pulse    (acc_pulse),
    .acc_addr     (acc_addr),
    .acc_data     (acc_data),
    .rd_reset_req (rd_reset_req),
    .in_write     (in_write)
  );
endmodule

// File: rtl/fwq_checker.sv
module fwq_checker (
  input logic clk,
  input logic rst_ni,
  input logic acc_pulse,
  input logic rd_reset_req,
  input logic lock,
  input logic in_write
);
  // R5
  one_cycle_acc_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    acc_pulse |=> !acc_pulse);

  // R6
  no_acc_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(lock) |-> !acc_pulse);

  // R7
  lock_rise_req_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(lock) |=> rd_reset_req);

  // R1
  acc_from_window_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    acc_pulse |-> $past(in_write));
endmodule

bind flash_wr_qualifier fwq_checker u_chk (
  .clk          (clk),
  .rst_ni       (rst_ni),
  .acc_pulse    (acc_pulse),
  .rd_reset_req (rd_reset_req),
  .lock         (lock_s),
  .in_write     (in_write)
);

// File: tb/sim_flash_wr_qualifier.sv
module sim_flash_wr_qualifier;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int MW = 3;

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, we_n, supply_low;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic acc_pulse, rd_reset_req;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_data;

  int n_run = 0, n_fail = 0;
  int n_acc = 0, n_long = 0, n_rd = 0;
  logic prev_acc = 1'b0, prev_rd = 1'b1;
  logic [AW-1:0] last_addr = '0;
  logic [DW-1:0] last_data = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_wr_qualifier #(.AW(AW), .DW(DW), .MIN_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .supply_low(supply_low), .bus_addr(bus_addr), .bus_data(bus_data),
    .acc_pulse(acc_pulse), .acc_addr(acc_addr), .acc_data(acc_data),
    .rd_reset_req(rd_reset_req)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (acc_pulse) begin
        n_acc++;
        if (prev_acc) n_long++;
        last_addr = acc_addr;
        last_data = acc_data;
      end
      if (rd_reset_req && !prev_rd) n_rd++;
      prev_acc = acc_pulse;
      prev_rd  = rd_reset_req;
    end
  end

  typedef struct packed {
    logic          ce_lo;
    logic          we_lo;
    logic          oe_v;
    logic [7:0]    width;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          exp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 1'b1, 8'd3,  19'h05555, 8'hAA, 1'b1},  // R1 exact width
    '{1'b1, 1'b1, 1'b1, 8'd2,  19'h02AAA, 8'h55, 1'b0},  // R4 one short
    '{1'b1, 1'b1, 1'b1, 8'd9,  19'h7FFFF, 8'hA0, 1'b1},  // R1 long
    '{1'b0, 1'b1, 1'b1, 8'd6,  19'h00010, 8'h11, 1'b0},  // R2 CE high
    '{1'b1, 1'b0, 1'b1, 8'd6,  19'h00020, 8'h22, 1'b0},  // R2 WE high
    '{1'b1, 1'b1, 1'b0, 8'd6,  19'h00030, 8'h33, 1'b0},  // R3 OE low
    '{1'b1, 1'b1, 1'b1, 8'd1,  19'h00040, 8'h44, 1'b0}   // R4 single cycle
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic ce_lo, input logic we_lo, input logic oe_v,
                       input int width, input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr = a;
    bus_data = d;
    ce_n = !ce_lo;
    we_n = !we_lo;
    oe_n = oe_v;
    idle(width);
    ce_n = 1'b1;
    we_n = 1'b1;
    oe_n = 1'b1;
    idle(12);
  endtask

  initial begin
    int base;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; supply_low = 1'b0;
    bus_addr = '0; bus_data = '0;
    idle(4);
    // R8 reset state
    check(rd_reset_req === 1'b1, "R8 rd_reset_req in reset", int'(rd_reset_req), 1);
    check(acc_pulse === 1'b0, "R8 acc_pulse in reset", int'(acc_pulse), 0);
    rst_n = 1'b1;
    idle(10);
    check(rd_reset_req === 1'b0, "R8 rd_reset_req released", int'(rd_reset_req), 0);
    check(n_acc == 0, "R8 no accept after reset", n_acc, 0);

    for (int i = 0; i < NV; i++) begin
      base = n_acc;
      drive(VEC[i].ce_lo, VEC[i].we_lo, VEC[i].oe_v, int'(VEC[i].width),
            VEC[i].addr, VEC[i].data);
      check((n_acc - base) == int'(VEC[i].exp), "R1/R2/R3/R4 vector accept count",
            n_acc - base, int'(VEC[i].exp));
      if (VEC[i].exp) begin
        check(last_addr == VEC[i].addr, "R5 captured address", int'(last_addr), int'(VEC[i].addr));
        check(last_data == VEC[i].data, "R5 captured data", int'(last_data), int'(VEC[i].data));
      end
    end
    check(n_long == 0, "R5 accept pulse width", n_long, 0);

    // R3 short OE dip inside a long write does not cancel it
    base = n_acc;
    bus_addr = 19'h12345; bus_data = 8'h5A;
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    idle(5);
    oe_n = 1'b0;
    idle(MW - 1);
    oe_n = 1'b1;
    idle(6);
    ce_n = 1'b1; we_n = 1'b1;
    idle(12);
    check((n_acc - base) == 1, "R3 short OE dip", n_acc - base, 1);

    // R6 and R7: lockout before a write
    base = n_acc;
    supply_low = 1'b1;
    idle(6);
    check(n_rd == 1, "R7 rd_reset_req on supply_low rise", n_rd, 1);
    drive(1'b1, 1'b1, 1'b1, 6, 19'h00077, 8'h77);
    check((n_acc - base) == 0, "R6 write while supply_low", n_acc - base, 0);
    check(n_long == 0, "R5 accept pulse width", n_long, 0);
    supply_low = 1'b0;
    idle(6);

    // R10 writes resume
    base = n_acc;
    drive(1'b1, 1'b1, 1'b1, 5, 19'h0ABCD, 8'hC3);
    check((n_acc - base) == 1, "R10 accept after supply_low falls", n_acc - base, 1);
    check(last_data == 8'hC3, "R10 captured data", int'(last_data), 8'hC3);

    // R9 abort in flight
    base = n_acc;
    bus_addr = 19'h00099; bus_data = 8'h99;
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    idle(6);
    supply_low = 1'b1;
    idle(6);
    ce_n = 1'b1; we_n = 1'b1;
    idle(6);
    supply_low = 1'b0;
    idle(12);
    check((n_acc - base) == 0, "R9 aborted write", n_acc - base, 0);
    check(n_rd == 2, "R7 second supply_low rise", n_rd, 2);

    // R9 aborted write leaves later writes working
    base = n_acc;
    drive(1'b1, 1'b1, 1'b1, 4, 19'h00100, 8'h0F);
    check((n_acc - base) == 1, "R9 accept after abort", n_acc - base, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule